// File: doc/BRIEF.md
# Interrupt Instruction Injector

This block gathers a set of interrupt source lines and presents one request to a processor whose interrupt vectoring is entirely external. Instead of returning a vector number, it answers the processor's acknowledge by handing over a complete instruction. The processor fetches that instruction through one special interrupt read cycle per byte.

Two encodings are available. The first is a one-byte restart opcode whose three-bit target field carries the winning source number. The second is a three-byte subroutine call to a programmable 16-bit base plus a fixed per-source stride.

Source lines are edge-captured into a pending set, and a mask input hides pending sources from arbitration. The lowest-numbered visible source wins. The choice of source, encoding and target is frozen at the moment acknowledge rises. The winner's pending bit is retired once its final byte has been read.

Top module: `irqInjector`

## Requirements
- R1: After reset `intReq` and `busDrive` are low and no source is pending.
- R2: A source becomes pending on a rising edge of its `srcReq` bit only; a line held high after its injection does not re-raise `intReq`.
- R3: `intReq` is high exactly when no injection is in progress and at least one pending source has its `srcMask` bit clear (1 = masked); a masked pending source alone leaves `intReq` low, and clearing the mask raises it.
- R4: Among unmasked pending sources the one with the lowest index is injected first.
- R5: With `modeCall` = 0 at acknowledge, a single byte `{2'b11, N[2:0], 3'b111}` is supplied, where N is the winning source index; this sends execution to address N*8.
- R6: With `modeCall` = 1 at acknowledge, three bytes are supplied over three read cycles: 8'hCD, then the low byte, then the high byte of `vecBase + N*8`, with the sum taken modulo 2^16.
- R7: Source, mode and vector are sampled on the rising edge of `intAck`; changes to `modeCall`, `vecBase` or new lower-index requests during an injection do not alter the bytes being supplied.
- R8: `intReq` stays low from the cycle after acknowledge rises until the last byte's read strobe falls; the winner's pending bit is then cleared, and `intReq` rises again if other unmasked sources are pending.
- R9: `busDrive` is high only while an injection is in progress and `intRead` is high; `busData` is zero otherwise. An acknowledge with nothing unmasked pending starts no injection.
- R10: A byte is advanced on the falling edge of `intRead`, so the byte stays stable for however many cycles the read strobe is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all state on rising edge |
| rst | input | 1 | Synchronous reset, active high |
| srcReq | input | NUM_SRC | Interrupt source lines, rising-edge captured |
| srcMask | input | NUM_SRC | Per-source mask, 1 hides the source from arbitration |
| modeCall | input | 1 | 0 = one-byte restart, 1 = three-byte call |
| vecBase | input | 16 | Base address for call mode targets |
| intAck | input | 1 | Interrupt acknowledge from the processor |
| intRead | input | 1 | Interrupt read strobe, one pulse per instruction byte |
| intReq | output | 1 | Interrupt request to the processor |
| busDrive | output | 1 | Enable for the data bus driver; high only while a byte is supplied |
| busData | output | 8 | Instruction byte for the current read cycle |

## Verification
The hardest situation to reach is a new request arriving, together with a change of mode and vector, in the middle of a three-byte call. The bench pulses source 0 and rewrites `modeCall` and `vecBase` between the first and second read cycles of a call injection for source 1. It then checks that the remaining call bytes are unchanged. It also checks that source 0 wins the next round, using the new mode. A second corner sets the base near the top of the address space so that the call target wraps past 16'hFFFF.

// File: rtl/injPkg.sv
package injPkg;
  // strobes from control to datapath
  typedef struct packed {
    logic freeze;   // capture winner, mode and target
    logic advance;  // step to next byte
    logic retire;   // last byte consumed, clear winner pending bit
  } injStrobes_t;

  localparam logic [7:0] CALL_OPCODE = 8'hCD;
  localparam int         ADDR_W      = 16;
endpackage

// File: rtl/injControl.sv
module injControl
  import injPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        intAck,
  input  logic        intRead,
  input  logic        anyActive,
  input  logic        lastByte,
  output injStrobes_t strobes,
  output logic        busy,
  output logic        intReq,
  output logic        busDrive
);
  logic ackPrev;
  logic readPrev;
  logic ackRise;
  logic readFall;

  assign ackRise  = intAck & ~ackPrev;
  assign readFall = readPrev & ~intRead;

  always_comb begin
    strobes.freeze  = ackRise & ~busy & anyActive;
    strobes.advance = busy & readFall & ~lastByte;
    strobes.retire  = busy & readFall & lastByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ackPrev  <= 1'b0;
      readPrev <= 1'b0;
      busy     <= 1'b0;
    end else begin
      ackPrev  <= intAck;
      readPrev <= intRead;
      if (strobes.freeze)      busy <= 1'b1;
      else if (strobes.retire) busy <= 1'b0;
    end
  end

  assign intReq   = ~busy & anyActive;
  assign busDrive = busy & intRead;
endmodule

// File: rtl/injDatapath.sv
module injDatapath
  import injPkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STRIDE_LOG2 = 3
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcMask,
  input  logic               modeCall,
  input  logic [ADDR_W-1:0]  vecBase,
  input  injStrobes_t        strobes,
  output logic               anyActive,
  output logic               lastByte,
  output logic [1:0]         byteIdx,
  output logic [7:0]         byteOut
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] pending;
  logic [NUM_SRC-1:0] active;
  logic [IDX_W-1:0]   winNext;
  logic [IDX_W-1:0]   winIdx;
  logic               winCall;
  logic [ADDR_W-1:0]  winTarget;
  logic [ADDR_W-1:0]  targetNext;
  logic [2:0]         rstNum;

  assign active    = pending & ~srcMask;
  assign anyActive = |active;

  // lowest index wins
  always_comb begin
    winNext = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (active[i]) winNext = IDX_W'(i);
    end
  end

  assign targetNext = vecBase + (ADDR_W'(winNext) << STRIDE_LOG2);

  always_ff @(posedge clk) begin
    if (rst) srcPrev <= '0;
    else     srcPrev <= srcReq;
  end

  // per-source pending bit: a fresh edge beats a retire in the same cycle
  for (genvar g = 0; g < NUM_SRC; g++) begin : gPend
    logic clrBit;
    assign clrBit = strobes.retire && (winIdx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (rst)                          pending[g] <= 1'b0;
      else if (srcReq[g] & ~srcPrev[g]) pending[g] <= 1'b1;
      else if (clrBit)                  pending[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winIdx    <= '0;
      winCall   <= 1'b0;
      winTarget <= '0;
      byteIdx   <= '0;
    end else if (strobes.freeze) begin
      winIdx    <= winNext;
      winCall   <= modeCall;
      winTarget <= targetNext;
      byteIdx   <= '0;
    end else if (strobes.advance) begin
      byteIdx   <= byteIdx + 2'd1;
    end
  end

  assign rstNum   = 3'(winIdx);
  assign lastByte = winCall ? (byteIdx == 2'd2) : 1'b1;

  always_comb begin
    if (!winCall) begin
      byteOut = {2'b11, rstNum, 3'b111};
    end else begin
      case (byteIdx)
        2'd0:    byteOut = CALL_OPCODE;
        2'd1:    byteOut = winTarget[7:0];
        default: byteOut = winTarget[15:8];
      endcase
    end
  end
endmodule

// File: rtl/irqInjector.sv
module irqInjector
  import injPkg::*;
#(
  parameter int NUM_SRC     = 8,
  parameter int STRIDE_LOG2 = 3
)(
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] srcReq,
  input  logic [NUM_SRC-1:0] srcMask,
  input  logic               modeCall,
  input  logic [15:0]        vecBase,
  input  logic               intAck,
  input  logic               intRead,
  output logic               intReq,
  output logic               busDrive,
  output logic [7:0]         busData
);
  injStrobes_t strobesW;
  logic        busyW;
  logic        anyActiveW;
  logic        lastByteW;
  logic [1:0]  byteIdxW;
  logic [7:0]  byteOutW;

  injControl uCtl (
    .clk(clk), .rst(rst), .intAck(intAck), .intRead(intRead),
    .anyActive(anyActiveW), .lastByte(lastByteW), .strobes(strobesW),
    .busy(busyW), .intReq(intReq), .busDrive(busDrive)
  );

  injDatapath #(.NUM_SRC(NUM_SRC), .STRIDE_LOG2(STRIDE_LOG2)) uDp (
    .clk(clk), .rst(rst), .srcReq(srcReq), .srcMask(srcMask),
    .modeCall(modeCall), .vecBase(vecBase), .strobes(strobesW),
    .anyActive(anyActiveW), .lastByte(lastByteW), .byteIdx(byteIdxW),
    .byteOut(byteOutW)
  );

  assign busData = busDrive ? byteOutW : 8'h00;
endmodule

// File: rtl/injChecker.sv
module injChecker (
  input logic       clk,
  input logic       rst,
  input logic       intReq,
  input logic       intRead,
  input logic       busDrive,
  input logic [7:0] busData,
  input logic       busy,
  input logic       anyActive,
  input logic [1:0] byteIdx
);
  p_req_needs_active_r3: assert property (@(posedge clk) disable iff (rst)
    !anyActive |-> !intReq);

  p_req_low_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !intReq);

  p_drive_window_r9: assert property (@(posedge clk) disable iff (rst)
    busDrive |-> (intRead && busy));

  p_first_byte_form_r5: assert property (@(posedge clk) disable iff (rst)
    (busDrive && byteIdx == 2'd0) |-> (busData[7:6] == 2'b11 && busData[0]));

  p_idx_range_r6: assert property (@(posedge clk) disable iff (rst)
    byteIdx != 2'd3);

  p_byte_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (busDrive && $past(busDrive)) |-> $stable(busData));
endmodule

bind irqInjector injChecker uChk (
  .clk(clk), .rst(rst), .intReq(intReq), .intRead(intRead),
  .busDrive(busDrive), .busData(busData), .busy(busyW),
  .anyActive(anyActiveW), .byteIdx(byteIdxW)
);

// File: tb/irqInjector_test.sv
module irqInjector_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] srcReq = '0;
  logic [7:0] srcMask = '0;
  logic       modeCall = 1'b0;
  logic [15:0] vecBase = '0;
  logic       intAck = 1'b0;
  logic       intRead = 1'b0;
  logic       intReq;
  logic       busDrive;
  logic [7:0] busData;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       prevDrive = 1'b0;

  always #10 clk = ~clk;

  irqInjector uut (
    .clk(clk), .rst(rst), .srcReq(srcReq), .srcMask(srcMask),
    .modeCall(modeCall), .vecBase(vecBase), .intAck(intAck),
    .intRead(intRead), .intReq(intReq), .busDrive(busDrive),
    .busData(busData)
  );

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pushRestart(int idx);
    expQ.push_back({2'b11, 3'(idx), 3'b111});
    tagQ.push_back("R5");
  endtask

  task automatic pushCall(int idx, logic [15:0] base);
    logic [15:0] t;
    t = base + 16'(idx * 8);
    expQ.push_back(8'hCD);   tagQ.push_back("R6");
    expQ.push_back(t[7:0]);  tagQ.push_back("R6");
    expQ.push_back(t[15:8]); tagQ.push_back("R6");
  endtask

  task automatic pulseSrc(int idx);
    srcReq[idx] = 1'b1;
    tick();
    srcReq[idx] = 1'b0;
  endtask

  // processor side: acknowledge, then n interrupt read cycles
  task automatic runInject(int n, bit expDrive, bit disturb);
    intAck = 1'b1;
    tick();
    @(negedge clk);
    check("R8 intReq during injection", 16'(intReq), 16'd0);
    tick();
    for (int b = 0; b < n; b++) begin
      intRead = 1'b1;
      @(negedge clk);
      check("R9 busDrive in read", 16'(busDrive), 16'(expDrive));
      tick();
      if (b == 0) begin
        // hold strobe a second cycle on the first byte (R10)
        @(negedge clk);
        check("R10 byte held", 16'(busDrive), 16'(expDrive));
        tick();
      end
      intRead = 1'b0;
      if (disturb && b == 0) begin
        srcReq[0] = 1'b1;
        modeCall  = ~modeCall;
        vecBase   = 16'h5555;
      end
      tick();
      srcReq[0] = 1'b0;
    end
    intAck = 1'b0;
    tick();
  endtask

  // monitor: one pop per read-cycle byte
  always @(negedge clk) begin
    if (!rst) begin
      if (busDrive && !prevDrive) begin
        checks++;
        if (expQ.size() == 0) begin
          failures++;
          $display("FAIL R9 unexpected drive actual=%h expected=none", busData);
        end else begin
          logic [7:0] e;
          string t;
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (busData !== e) begin
            failures++;
            $display("FAIL %s byte actual=%h expected=%h", t, busData, e);
          end
        end
      end
      prevDrive = busDrive;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(20 * 20000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    finish();
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0;
    @(negedge clk);
    check("R1 intReq after reset", 16'(intReq), 16'd0);
    check("R1 busDrive after reset", 16'(busDrive), 16'd0);
    tick();

    // restart mode, source 3
    pulseSrc(3);
    @(negedge clk);
    check("R3 intReq on pending", 16'(intReq), 16'd1);
    tick();
    pushRestart(3);
    runInject(1, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 pending cleared", 16'(intReq), 16'd0);
    tick();

    // level held after injection does not re-latch
    srcReq[5] = 1'b1;
    tick();
    pushRestart(5);
    runInject(1, 1'b1, 1'b0);
    @(negedge clk);
    check("R2 held level no re-request", 16'(intReq), 16'd0);
    tick();
    srcReq[5] = 1'b0;
    tick();

    // mask behaviour
    srcMask = 8'h02;
    pulseSrc(1);
    @(negedge clk);
    check("R3 masked pending", 16'(intReq), 16'd0);
    tick();
    srcMask = 8'h00;
    @(negedge clk);
    check("R3 unmasked pending", 16'(intReq), 16'd1);
    tick();
    pulseSrc(6);

    // call mode, source 1 wins over 6; disturbed mid-injection
    modeCall = 1'b1;
    vecBase  = 16'h1200;
    pushCall(1, 16'h1200);   // R4: lower index first
    runInject(3, 1'b1, 1'b1);
    @(negedge clk);
    check("R8 re-request after retire", 16'(intReq), 16'd1);
    check("R7 all call bytes seen", 16'(expQ.size()), 16'd0);
    tick();

    // source 0 arrived during injection; mode now restart (R7, R4)
    pushRestart(0);
    runInject(1, 1'b1, 1'b0);
    @(negedge clk);
    check("R4 source 6 still pending", 16'(intReq), 16'd1);
    tick();

    // source 6, call with wrapping target
    modeCall = 1'b1;
    vecBase  = 16'hFFF0;
    pushCall(6, 16'hFFF0);
    runInject(3, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 all retired", 16'(intReq), 16'd0);
    check("R6 queue drained", 16'(expQ.size()), 16'd0);
    tick();

    // acknowledge with nothing pending
    runInject(1, 1'b0, 1'b0);
    @(negedge clk);
    check("R9 no drive idle", 16'(busDrive), 16'd0);
    check("R9 idle busData zero", 16'(busData), 16'd0);
    tick();

    finish();
  end
endmodule